// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers interrupt events from two Ethernet PHY ports, twelve general-purpose I/O lines and five host MAC sources, and drives a single active-high interrupt request output. Each source arrives as a one-cycle event strobe and is latched into a sticky flag. PHY and GPIO flags live in second-level registers, each with its own per-bit enable. A top-level status word carries one read-only summary bit per second-level register together with the MAC flags, which have no second level. A top-level enable word selects which of these bits may reach the output, and a configuration bit gates the output as a whole.

Software finds the cause of an interrupt by reading the top-level status word first and then the second-level register it points to. It clears a cause by writing a one to that flag. Because flags are recorded whether or not they are enabled, software can poll masked sources, and enabling a source later raises the request at once if its flag is still pending.

Register map (word addresses): 0 top status, 1 top enable, 2 configuration, 3 GPIO status/enable, 4 PHY port 0 flags, 5 PHY port 0 mask, 6 PHY port 1 flags, 7 PHY port 1 mask. Addresses 8 to 15 read as zero.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A strobe on PHY port p event bit b (`phy_evt[7*p+b]`) sets bit b of that port's flag register (address 4+2p, bits [6:0]) on the next clock edge, even when the mask bit is clear.
- R3: Writing a 1 to a flag bit clears it. Writing 0 leaves it unchanged. Flags otherwise hold their value.
- R4: When an event strobe and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R5: Top status bit 26+p is the OR over port p of flag AND mask (mask register at address 5+2p, bits [6:0]). It is read-only: writes to it have no effect, and it falls only when the underlying flags are cleared or masked.
- R6: The GPIO register (address 3) holds the sticky, write-one-to-clear status of line g in bit g and the read/write enable of line g in bit 16+g. Top status bit 12 is the OR of status AND enable.
- R7: A strobe on `mac_evt[m]` sets top status bit m (m = 0..4) directly. That bit is cleared by writing 1 to it at address 0.
- R8: `irq` is a registered output. It is high one cycle after configuration bit 8 is set and some top status bit is set together with its top enable bit (enable implemented at bits 27, 26, 12 and 4..0).
- R9: Clearing configuration bit 8 drops `irq` on the next cycle and leaves every status and flag unchanged.
- R10: Setting a mask or enable on an already pending flag raises `irq` without any new event.
- R11: Read data appears one cycle after the address is presented. Unimplemented bits and addresses 8..15 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable for the addressed register |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| phy_evt | input | 14 | PHY event strobes, port p bits [7p+6:7p] |
| gpio_evt | input | 12 | GPIO line event strobes |
| mac_evt | input | 5 | Host MAC event strobes |
| irq | output | 1 | Active-high interrupt request |

## Verification
A flag that fails to latch, or that clears when it should not, shows up on the next read of its register and, once its path is enabled, as a missing or stuck `irq` two cycles after the event. A summary bit that is computed wrongly shows at address 0 as soon as the mask is changed. A wrong gating term shows as `irq` disagreeing with the enable state one cycle after the last configuration write. The sweeps walk every source bit through its masked, enabled, output-gated and cleared states, so each bit position is seen both alone and at its routing boundary.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 4;
    localparam int NUM_PHY      = 2;
    localparam int PHY_SRC_N    = 7;
    localparam int GPIO_N       = 12;
    localparam int MAC_N        = 5;
    // bit positions that software decodes
    localparam int TOP_PHY_BIT  = 26;
    localparam int TOP_GPIO_BIT = 12;
    localparam int CFG_OE_BIT   = 8;
    localparam int GPIO_EN_LSB  = 16;
    // word addresses
    localparam int A_TOP_STAT   = 0;
    localparam int A_TOP_EN     = 1;
    localparam int A_CFG        = 2;
    localparam int A_GPIO       = 3;
    localparam int A_PHY_BASE   = 4;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // a set in the same cycle as a clear takes precedence
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_i) | set_i;
    end

    assign q_o = q;
endmodule

// File: rtl/irq_phy_port.sv
module irq_phy_port #(
    parameter int SRC_N = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt_i,
    input  logic             flag_wr_i,
    input  logic             mask_wr_i,
    input  logic [SRC_N-1:0] wdata_i,
    output logic [SRC_N-1:0] flags_o,
    output logic [SRC_N-1:0] mask_o,
    output logic             summary_o
);
    logic [SRC_N-1:0] clr;
    logic [SRC_N-1:0] mask_q;

    assign clr = flag_wr_i ? wdata_i : '0;

    irq_sticky_bank #(.W(SRC_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_i),
        .clr_i (clr),
        .q_o   (flags_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= wdata_i;
    end

    assign mask_o    = mask_q;
    assign summary_o = |(flags_o & mask_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N_PHY  = NUM_PHY,
    parameter int SRC_N  = PHY_SRC_N,
    parameter int N_GPIO = GPIO_N,
    parameter int N_MAC  = MAC_N
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    input  logic                     reg_we,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [N_PHY*SRC_N-1:0]   phy_evt,
    input  logic [N_GPIO-1:0]        gpio_evt,
    input  logic [N_MAC-1:0]         mac_evt,
    output logic                     irq
);
    localparam int PHY_END = A_PHY_BASE + 2 * N_PHY;

    logic [N_PHY*SRC_N-1:0] phy_flags_all;
    logic [N_PHY*SRC_N-1:0] phy_mask_all;
    logic [N_PHY-1:0]       phy_sum;
    logic [N_GPIO-1:0]      gpio_q;
    logic [N_GPIO-1:0]      gpio_en_q;
    logic [N_GPIO-1:0]      gpio_clr;
    logic [N_MAC-1:0]       mac_q;
    logic [N_MAC-1:0]       mac_clr;
    logic [DATA_W-1:0]      top_en_q;
    logic [DATA_W-1:0]      en_impl;
    logic [DATA_W-1:0]      top_stat;
    logic                   cfg_oe_q;
    logic                   irq_q;
    logic [DATA_W-1:0]      rd_next;
    logic [DATA_W-1:0]      rdata_q;

    // second level: one flag/mask pair per PHY port
    for (genvar p = 0; p < N_PHY; p++) begin : g_phy
        logic flag_wr, mask_wr;
        assign flag_wr = reg_we && (reg_addr == ADDR_W'(A_PHY_BASE + 2*p));
        assign mask_wr = reg_we && (reg_addr == ADDR_W'(A_PHY_BASE + 2*p + 1));

        irq_phy_port #(.SRC_N(SRC_N)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (phy_evt[p*SRC_N +: SRC_N]),
            .flag_wr_i (flag_wr),
            .mask_wr_i (mask_wr),
            .wdata_i   (reg_wdata[SRC_N-1:0]),
            .flags_o   (phy_flags_all[p*SRC_N +: SRC_N]),
            .mask_o    (phy_mask_all[p*SRC_N +: SRC_N]),
            .summary_o (phy_sum[p])
        );
    end

    // second level: GPIO status with enables in the same word
    assign gpio_clr = (reg_we && reg_addr == ADDR_W'(A_GPIO)) ? reg_wdata[N_GPIO-1:0] : '0;

    irq_sticky_bank #(.W(N_GPIO)) u_gpio (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (gpio_evt),
        .clr_i (gpio_clr),
        .q_o   (gpio_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            gpio_en_q <= '0;
        else if (reg_we && reg_addr == ADDR_W'(A_GPIO))
            gpio_en_q <= reg_wdata[GPIO_EN_LSB +: N_GPIO];
    end

    // MAC flags sit directly in the top status word
    assign mac_clr = (reg_we && reg_addr == ADDR_W'(A_TOP_STAT)) ? reg_wdata[N_MAC-1:0] : '0;

    irq_sticky_bank #(.W(N_MAC)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (mac_evt),
        .clr_i (mac_clr),
        .q_o   (mac_q)
    );

    // implemented top-level bit positions
    always_comb begin
        en_impl                 = '0;
        en_impl[N_MAC-1:0]      = '1;
        en_impl[TOP_GPIO_BIT]   = 1'b1;
        for (int p = 0; p < N_PHY; p++) en_impl[TOP_PHY_BIT + p] = 1'b1;
    end

    always_comb begin
        top_stat               = '0;
        top_stat[N_MAC-1:0]    = mac_q;
        top_stat[TOP_GPIO_BIT] = |(gpio_q & gpio_en_q);
        for (int p = 0; p < N_PHY; p++) top_stat[TOP_PHY_BIT + p] = phy_sum[p];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_en_q <= '0;
            cfg_oe_q <= 1'b0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_W'(A_TOP_EN)) top_en_q <= reg_wdata & en_impl;
            if (reg_addr == ADDR_W'(A_CFG))    cfg_oe_q <= reg_wdata[CFG_OE_BIT];
        end
    end

    // output request, registered
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= cfg_oe_q && (|(top_stat & top_en_q));
    end
    assign irq = irq_q;

    // read path
    always_comb begin
        rd_next = '0;
        if (reg_addr == ADDR_W'(A_TOP_STAT)) rd_next = top_stat;
        if (reg_addr == ADDR_W'(A_TOP_EN))   rd_next = top_en_q;
        if (reg_addr == ADDR_W'(A_CFG))      rd_next[CFG_OE_BIT] = cfg_oe_q;
        if (reg_addr == ADDR_W'(A_GPIO)) begin
            rd_next[N_GPIO-1:0]              = gpio_q;
            rd_next[GPIO_EN_LSB +: N_GPIO]   = gpio_en_q;
        end
        for (int p = 0; p < N_PHY; p++) begin
            if (reg_addr == ADDR_W'(A_PHY_BASE + 2*p))
                rd_next[SRC_N-1:0] = phy_flags_all[p*SRC_N +: SRC_N];
            if (reg_addr == ADDR_W'(A_PHY_BASE + 2*p + 1))
                rd_next[SRC_N-1:0] = phy_mask_all[p*SRC_N +: SRC_N];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_next;
    end
    assign reg_rdata = rdata_q;

    logic unused_end;
    assign unused_end = (PHY_END > 0);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int N_PHY = NUM_PHY,
    parameter int SRC_N = PHY_SRC_N,
    parameter int N_MAC = MAC_N
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic                   reg_we,
    input logic [DATA_W-1:0]      reg_rdata,
    input logic [N_PHY*SRC_N-1:0] phy_evt,
    input logic [N_MAC-1:0]       mac_evt,
    input logic                   irq,
    input logic [N_PHY*SRC_N-1:0] phy_flags,
    input logic [N_MAC-1:0]       mac_stat,
    input logic                   cfg_oe
);
    localparam logic [ADDR_W-1:0] FIRST_FREE = ADDR_W'(A_PHY_BASE + 2 * N_PHY);

    assert_evt_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((phy_flags & $past(phy_evt)) == $past(phy_evt)));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mac_stat & $past(mac_evt)) == $past(mac_evt)));

    assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && phy_evt == '0) |=> $stable(phy_flags));

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_oe |=> !irq);

    assert_unimpl_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= FIRST_FREE) |=> (reg_rdata == '0));
endmodule

bind irq_aggregator irq_aggregator_chk #(
    .N_PHY (N_PHY),
    .SRC_N (SRC_N),
    .N_MAC (N_MAC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .phy_evt   (phy_evt),
    .mac_evt   (mac_evt),
    .irq       (irq),
    .phy_flags (phy_flags_all),
    .mac_stat  (mac_q),
    .cfg_oe    (cfg_oe_q)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [13:0] phy_evt = '0;
    logic [11:0] gpio_evt = '0;
    logic [4:0]  mac_evt = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .phy_evt(phy_evt),
        .gpio_evt(gpio_evt), .mac_evt(mac_evt), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = 4'(a);
        @(posedge clk);
        @(negedge clk);
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic irq_chk(input logic exp, input string req);
        check(irq == exp, req, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        irq_chk(1'b0, "R1 irq after reset");
        for (int a = 0; a < 16; a++)
            rd_chk(a, 32'h0, a < 8 ? "R1 reset value" : "R11 unused address");

        // PHY sweep over every port and source
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 7; b++) begin
                logic [31:0] fb, sb;
                fb = 32'd1 << b;
                sb = 32'd1 << (26 + p);
                @(negedge clk); phy_evt[7*p + b] = 1'b1;
                @(negedge clk); phy_evt = '0;
                rd_chk(4 + 2*p, fb, "R2 masked flag recorded");
                rd_chk(0, 32'h0, "R5 masked summary low");
                irq_chk(1'b0, "R8 masked no irq");
                wr(2, 32'h100);
                wr(1, sb);
                idle(1);
                irq_chk(1'b0, "R8 mask clear blocks irq");
                wr(5 + 2*p, fb);
                idle(1);
                irq_chk(1'b1, "R10 late mask raises irq");
                rd_chk(0, sb, "R5 summary bit");
                rd_chk(5 + 2*p, fb, "R5 mask readback");
                wr(0, sb);
                rd_chk(0, sb, "R5 summary read-only");
                wr(4 + 2*p, 32'h0);
                rd_chk(4 + 2*p, fb, "R3 zero write no effect");
                wr(4 + 2*p, fb);
                idle(1);
                irq_chk(1'b0, "R3 clear drops irq");
                rd_chk(4 + 2*p, 32'h0, "R3 flag cleared");
                wr(5 + 2*p, 0); wr(1, 0); wr(2, 0);
            end
        end

        // GPIO sweep
        for (int g = 0; g < 12; g++) begin
            logic [31:0] st, en;
            st = 32'd1 << g;
            en = 32'd1 << (16 + g);
            @(negedge clk); gpio_evt[g] = 1'b1;
            @(negedge clk); gpio_evt = '0;
            rd_chk(3, st, "R6 gpio status");
            wr(3, en);
            rd_chk(3, st | en, "R6 gpio enable readback");
            wr(1, 32'h1000);
            wr(2, 32'h100);
            idle(1);
            irq_chk(1'b1, "R8 gpio irq");
            rd_chk(0, 32'h1000, "R6 gpio summary");
            wr(2, 0);
            idle(1);
            irq_chk(1'b0, "R9 output gate off");
            rd_chk(3, st | en, "R9 status kept");
            wr(3, st | en);
            rd_chk(3, en, "R6 gpio w1c");
            wr(3, 0); wr(1, 0);
        end

        // MAC sweep
        for (int m = 0; m < 5; m++) begin
            logic [31:0] mb;
            mb = 32'd1 << m;
            @(negedge clk); mac_evt[m] = 1'b1;
            @(negedge clk); mac_evt = '0;
            rd_chk(0, mb, "R7 mac status");
            wr(1, mb);
            wr(2, 32'h100);
            idle(1);
            irq_chk(1'b1, "R8 mac irq");
            wr(0, mb);
            idle(1);
            irq_chk(1'b0, "R7 mac clear drops irq");
            rd_chk(0, 32'h0, "R7 mac cleared");
            wr(1, 0); wr(2, 0);
        end

        // set wins over same-cycle clear
        @(negedge clk); phy_evt[3] = 1'b1;
        @(negedge clk); phy_evt = '0;
        @(negedge clk);
        phy_evt[3] = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h8; reg_we = 1'b1;
        @(negedge clk);
        phy_evt = '0; reg_we = 1'b0;
        rd_chk(4, 32'h8, "R4 phy set wins");
        @(negedge clk);
        mac_evt[2] = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h4; reg_we = 1'b1;
        @(negedge clk);
        mac_evt = '0; reg_we = 1'b0;
        rd_chk(0, 32'h4, "R4 mac set wins");
        wr(4, 32'h8); wr(0, 32'h4);
        rd_chk(0, 32'h0, "R3 cleanup");

        // unimplemented bits
        wr(1, 32'hFFFF_FFFF);
        rd_chk(1, 32'h0C00_101F, "R11 enable implemented bits");
        wr(2, 32'hFFFF_FFFF);
        rd_chk(2, 32'h0000_0100, "R11 config bits");
        wr(7, 32'hFFFF_FFFF);
        rd_chk(7, 32'h0000_007F, "R11 mask bits");
        wr(3, 32'hFFFF_FFFF);
        rd_chk(3, 32'h0FFF_0000, "R11 gpio bits");
        irq_chk(1'b0, "R8 nothing pending");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule